// File: doc/BRIEF.md
# Two-Floor Lift Motor Controller

This block commands the hoist of a lift that serves two floors. It watches one position sensor per floor and one call key per floor. From these it drives two motor enables, one for upward and one for downward travel. A trip is armed while the call key for the other floor is held with the cabin parked. The motor only starts once that key is let go. It keeps running while the cabin is between floors and stops as soon as the sensor of the destination floor reports the cabin.

Each direction has a set/clear state register. The register for one direction can only be armed while the register for the other direction is idle and the cabin sits at the floor it starts from. Each motor enable is registered. Its next value is that register's next state masked by the inverse of the matching call key. Every input therefore shows at the outputs one clock edge after it is sampled. A synchronous active-high reset clears both direction registers and both outputs.

Top module: `lift2_ctrl`

## Requirements
- R1: While `rst` is 1 at a clock edge, both `motor_up` and `motor_down` are 0 after that edge. A trip that was under way is cancelled, so after reset the motors stay off until a new key press and release.
- R2: With the cabin at the ground floor (`at_ground`=1), holding `call_first` keeps `motor_up` at 0. After the first edge that samples `call_first` back at 0, `motor_up` is 1.
- R3: Once started, `motor_up` stays 1 while both sensors read 0. It drops to 0 after the first edge that samples `at_first`=1.
- R4: With the cabin at the first floor (`at_first`=1), holding `call_ground` keeps `motor_down` at 0. After the edge that samples it released, `motor_down` is 1. The motor stays 1 between floors and drops after the edge that samples `at_ground`=1.
- R5: A call key for the floor where the cabin already stands never sets either motor output, whether the key is held or released.
- R6: `motor_up` and `motor_down` are never 1 in the same cycle. A direction cannot be armed while the other direction's register is set.
- R7: All outputs are registered. A change of any input shows at the outputs after exactly one rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| at_ground | input | 1 | 1 while the cabin is at the ground floor |
| at_first | input | 1 | 1 while the cabin is at the first floor |
| call_ground | input | 1 | 1 while the key requesting the ground floor is held |
| call_first | input | 1 | 1 while the key requesting the first floor is held |
| motor_up | output | 1 | Upward motor enable |
| motor_down | output | 1 | Downward motor enable |

## Verification
The hardest state to reach is the one where a direction register is already set but its motor is still masked because the key is held. From the ports it looks the same as an idle controller. The stimulus therefore sweeps the hold length of each key from the ground floor and from the first floor. It checks that the outputs stay at 0 through every held cycle and rise exactly one edge after release. The stimulus also cuts a running trip short with reset, which shows that the hidden register was cleared and not merely masked.

// File: rtl/lift_pkg.sv
package lift_pkg;
  localparam int NUM_FLOORS = 2;
  localparam int DIR_W      = $clog2(NUM_FLOORS);
  typedef enum logic [DIR_W-1:0] {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/motor_latch.sv
module motor_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic nxt_o
);
  always_comb begin
    nxt_o = q_o;
    if (set_i) nxt_o = 1'b1;
    if (clr_i) nxt_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/release_gate.sv
module release_gate (
  input  logic clk,
  input  logic rst,
  input  logic armed_i,
  input  logic key_i,
  output logic drive_o
);
  always_ff @(posedge clk) begin
    if (rst) drive_o <= 1'b0;
    else     drive_o <= armed_i & ~key_i;
  end
endmodule

// File: rtl/lift2_ctrl.sv
module lift2_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic at_ground,
  input  logic at_first,
  input  logic call_ground,
  input  logic call_first,
  output logic motor_up,
  output logic motor_down
);
  import lift_pkg::*;

  logic [NUM_FLOORS-1:0] sensor;
  logic [NUM_FLOORS-1:0] key;
  logic [NUM_FLOORS-1:0] arm_q;
  logic [NUM_FLOORS-1:0] arm_nx;
  logic [NUM_FLOORS-1:0] drive;

  assign sensor = {at_first, at_ground};
  assign key    = {call_first, call_ground};

  // index d: direction whose destination floor is d (0 = down, 1 = up)
  for (genvar d = 0; d < NUM_FLOORS; d++) begin : g_dir
    localparam int TGT = d;
    localparam int ORG = NUM_FLOORS - 1 - d;
    logic set_c, clr_c;
    assign set_c = key[TGT] & sensor[ORG] & ~arm_q[ORG];
    assign clr_c = sensor[TGT];

    motor_latch u_latch (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_c),
      .clr_i (clr_c),
      .q_o   (arm_q[d]),
      .nxt_o (arm_nx[d])
    );

    release_gate u_gate (
      .clk     (clk),
      .rst     (rst),
      .armed_i (arm_nx[d]),
      .key_i   (key[TGT]),
      .drive_o (drive[d])
    );
  end

  assign motor_up   = drive[DIR_UP];
  assign motor_down = drive[DIR_DOWN];

  // R6: never both directions
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(motor_up && motor_down));
  // R1: reset clears outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!motor_up && !motor_down));
  // R2: held up key masks the motor
  a_r2_held_masks: assert property (@(posedge clk) disable iff (rst)
    call_first |=> !motor_up);
  // R3: arrival at first floor stops upward travel
  a_r3_stop_up: assert property (@(posedge clk) disable iff (rst)
    at_first |=> !motor_up);
  // R4: arrival at ground stops downward travel
  a_r4_stop_down: assert property (@(posedge clk) disable iff (rst)
    at_ground |=> !motor_down);
  // R6: the two direction registers never both set
  a_r6_latch_interlock: assert property (@(posedge clk) disable iff (rst)
    !(arm_q[0] && arm_q[1]));
endmodule

// File: tb/lift2_ctrl_tb.sv
module lift2_ctrl_tb;
  logic clk = 1'b0;
  logic rst, at_ground, at_first, call_ground, call_first;
  logic motor_up, motor_down;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lift2_ctrl u_dut (
    .clk(clk), .rst(rst), .at_ground(at_ground), .at_first(at_first),
    .call_ground(call_ground), .call_first(call_first),
    .motor_up(motor_up), .motor_down(motor_down)
  );

  task automatic chk(input string req, input logic exp_up, input logic exp_dn);
    n_chk++;
    if (motor_up !== exp_up || motor_down !== exp_dn) begin
      n_bad++;
      $display("FAIL %s: up/down actual %b%b expected %b%b", req,
               motor_up, motor_down, exp_up, exp_dn);
    end
    n_chk++;
    if (motor_up === 1'b1 && motor_down === 1'b1) begin
      n_bad++;
      $display("FAIL R6: up/down actual 11 expected not both");
    end
  endtask

  task automatic park(input int floor);
    at_ground = (floor == 0);
    at_first  = (floor == 1);
  endtask

  // start floor, key index, hold cycles, travel cycles
  task automatic trip(input int start, input int kidx, input int hold, input int travel);
    logic moves, eu, ed;
    moves = (kidx != start);
    eu = moves && (kidx == 1);
    ed = moves && (kidx == 0);
    @(negedge clk); park(start); call_ground = 0; call_first = 0;
    @(negedge clk); @(negedge clk);
    chk("R5 idle", 1'b0, 1'b0);
    for (int h = 0; h < hold; h++) begin
      if (h == 0) begin
        if (kidx == 0) call_ground = 1; else call_first = 1;
      end
      @(negedge clk);
      chk(kidx == 1 ? "R2 held key" : "R4 held key", 1'b0, 1'b0);
    end
    call_ground = 0; call_first = 0;
    @(negedge clk);
    chk(moves ? (kidx == 1 ? "R2 start on release" : "R4 start on release")
              : "R5 same floor", eu, ed);
    if (moves) begin
      at_ground = 0; at_first = 0;
      for (int t = 0; t < travel; t++) begin
        @(negedge clk);
        chk(kidx == 1 ? "R3 between floors" : "R4 between floors", eu, ed);
      end
      park(kidx);
      chk("R7 no early stop", eu, ed);
      @(negedge clk);
      chk(kidx == 1 ? "R3 stop at arrival" : "R4 stop at arrival", 1'b0, 1'b0);
    end
    @(negedge clk);
    chk("R5 stays off", 1'b0, 1'b0);
  endtask

  initial begin
    rst = 1; call_ground = 0; call_first = 0; park(0);
    repeat (3) @(negedge clk);
    chk("R1 reset state", 1'b0, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 1'b0);

    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 2; k++)
        for (int h = 1; h <= 3; h++)
          trip(s, k, h, h + 1);

    // R7: release is visible only after one edge
    @(negedge clk); park(0); call_first = 1;
    @(negedge clk); call_first = 0;
    #1 chk("R7 not before edge", 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 after one edge", 1'b1, 1'b0);
    // R1: reset cancels a running trip
    at_ground = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset cancels trip", 1'b0, 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk("R1 stays off after reset", 1'b0, 1'b0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule